// File: doc/BRIEF.md
# Pivot Window Readout Serializer

This block sits on a drift-tube front-end card that keeps one latched drift count for every tube in three stacked layers. When a request names a pivot tube in the middle layer, it takes a snapshot of the 3x3 window around that pivot: the pivot, its two neighbours in the middle layer, and the three tubes on each of the layers below and above. It packs these nine counts into a fixed-length frame and shifts that frame out one bit at a time toward a tower-level collector.

The frame has a fixed layout, so the position of a value in the frame tells the receiver which tube it came from and no tube addresses are sent. A sync pattern opens the frame. Then come the nine 7-bit counts, then one even-parity bit for each count, and a final bit that gives the whole frame even parity. With the default parameters the frame is 80 bits long. The bit period is a whole number of clock cycles, set by a parameter, so the block can match a slower serial link. While a frame is being sent the block reports busy and ignores any new request.

Top module: `pivot_window_serializer`

## Requirements
- R1: After reset, `busy` and `serOut` are low, and `serOut` stays low whenever `busy` is low.
- R2: A request (`reqValid` high while `busy` is low) is taken at a clock edge. From the next cycle `busy` is high and the first frame bit is on `serOut`.
- R3: The first 7 frame bits are the sync pattern 1110010, sent left to right.
- R4: Frame bits 7 to 69 carry nine 7-bit values, MSB first, in slot order. Slot k (k = 0..8) holds the tube at layer k/3 (0 = lowest layer in `driftCounts`) and column pivot + (k mod 3) - 1, so the pivot is slot 4. Tube (layer L, column c) is `driftCounts[(L*TUBES+c)*7 +: 7]`.
- R5: A window column below 0 or above TUBES-1 is sent as the value zero.
- R6: Frame bits 70 to 78 are one even-parity bit for each slot, in slot order. Each bit is the XOR of the seven bits of that slot's value.
- R7: Frame bit 79 makes the number of ones in the whole 80-bit frame even.
- R8: Each frame bit is held for exactly CLKS_PER_BIT cycles. `busy` stays high for exactly 80*CLKS_PER_BIT cycles and then drops.
- R9: A request made while `busy` is high is ignored. The current frame continues unchanged, and no frame follows it unless a new request comes after `busy` has dropped.
- R10: The drift counts and the pivot are sampled only at the edge where the request is taken. Later changes to them do not affect the frame being sent.
- R11: If `reqValid` is held high, the next frame is taken on the first cycle that `busy` is low, so successive frames are separated by one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Readout request |
| reqPivot | input | $clog2(TUBES) | Column of the pivot tube in the middle layer |
| driftCounts | input | 3*TUBES*7 | Latched drift counts of every tube, layer-major |
| busy | output | 1 | High while a frame is being sent |
| serOut | output | 1 | Serial frame bit, MSB first |

## Verification
The bench uses TUBES = 8 and CLKS_PER_BIT = 2. With eight tubes per layer, pivots 0 and 7 push the window past both edges of a layer, so zero fill at both edges is exercised, and a middle pivot gives a fully populated window. A bit period of two cycles makes it possible to tell a held bit from a shifted one, so a counter that moves one cycle too early or too late shows up as a mismatch. The 80-bit frame is short enough that back-to-back frames, requests in the middle of a frame and count changes during a frame all fit in one short run.

// File: rtl/pws_pkg.sv
`timescale 1ns/1ps
package pws_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic load;   // capture a new frame word
    logic shift;  // advance to the next frame bit
  } ctlStrobes_t;

  localparam int NUM_LAYERS = 3;
  localparam int NUM_SLOTS  = 9;
endpackage

// File: rtl/pws_ctrl.sv
`timescale 1ns/1ps
module pws_ctrl
  import pws_pkg::*;
#(
  parameter int FRAME_LEN    = 80,
  parameter int CLKS_PER_BIT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  output logic        busy,
  output ctlStrobes_t strobes
);
  localparam int DIV_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BIT_W = $clog2(FRAME_LEN);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_BIT - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_LEN - 1);

  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             bitEnd;

  assign bitEnd = (divCnt == DIV_LAST);

  always_comb begin
    strobes       = '0;
    strobes.load  = !busy && reqValid;
    strobes.shift = busy && bitEnd && (bitCnt != BIT_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (strobes.load) begin
      busy   <= 1'b1;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (busy) begin
      if (bitEnd) begin
        divCnt <= '0;
        if (bitCnt == BIT_LAST) busy <= 1'b0;
        else                    bitCnt <= bitCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pws_datapath.sv
`timescale 1ns/1ps
module pws_datapath
  import pws_pkg::*;
#(
  parameter int TUBES     = 8,
  parameter int VAL_W     = 7,
  parameter int SYNC_W    = 7,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 7'b1110010,
  parameter int FRAME_LEN = SYNC_W + NUM_SLOTS*VAL_W + NUM_SLOTS + 1,
  parameter int IDX_W     = (TUBES > 1) ? $clog2(TUBES) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  ctlStrobes_t                       strobes,
  input  logic [IDX_W-1:0]                  reqPivot,
  input  logic [NUM_LAYERS*TUBES*VAL_W-1:0] driftCounts,
  output logic                              bitOut
);
  localparam int BODY_W   = FRAME_LEN - 1;
  localparam int DATA_TOP = BODY_W - 1 - SYNC_W;
  localparam int PAR_TOP  = DATA_TOP - NUM_SLOTS*VAL_W;

  logic [VAL_W-1:0]     tubeArr [NUM_LAYERS][TUBES];
  logic [BODY_W-1:0]    bodyWord;
  logic [FRAME_LEN-1:0] frameWord;
  logic [FRAME_LEN-1:0] shiftReg;

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
    for (genvar t = 0; t < TUBES; t++) begin : g_tube
      assign tubeArr[l][t] = driftCounts[(l*TUBES + t)*VAL_W +: VAL_W];
    end
  end

  assign bodyWord[BODY_W-1 -: SYNC_W] = SYNC_WORD;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int ROW     = s / 3;
    localparam int COL_OFF = (s % 3) - 1;
    int               colIdx;
    logic [VAL_W-1:0] slotVal;
    always_comb begin
      colIdx = int'(reqPivot) + COL_OFF;
      if (colIdx < 0 || colIdx >= TUBES) slotVal = '0;
      else                               slotVal = tubeArr[ROW][colIdx[IDX_W-1:0]];
    end
    assign bodyWord[DATA_TOP - s*VAL_W -: VAL_W] = slotVal;
    assign bodyWord[PAR_TOP - s]                 = ^slotVal;
  end

  assign frameWord = {bodyWord, ^bodyWord};

  always_ff @(posedge clk) begin
    if (!rst_n)             shiftReg <= '0;
    else if (strobes.load)  shiftReg <= frameWord;
    else if (strobes.shift) shiftReg <= {shiftReg[FRAME_LEN-2:0], 1'b0};
  end

  assign bitOut = shiftReg[FRAME_LEN-1];
endmodule

// File: rtl/pivot_window_serializer.sv
`timescale 1ns/1ps
module pivot_window_serializer
  import pws_pkg::*;
#(
  parameter int TUBES        = 8,
  parameter int VAL_W        = 7,
  parameter int CLKS_PER_BIT = 2,
  parameter int SYNC_W       = 7,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 7'b1110010,
  localparam int IDX_W       = (TUBES > 1) ? $clog2(TUBES) : 1,
  localparam int FRAME_LEN   = SYNC_W + NUM_SLOTS*VAL_W + NUM_SLOTS + 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reqValid,
  input  logic [IDX_W-1:0]                  reqPivot,
  input  logic [NUM_LAYERS*TUBES*VAL_W-1:0] driftCounts,
  output logic                              busy,
  output logic                              serOut
);
  ctlStrobes_t strobes;
  logic        bitOut;

  pws_ctrl #(.FRAME_LEN(FRAME_LEN), .CLKS_PER_BIT(CLKS_PER_BIT)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .busy(busy), .strobes(strobes)
  );

  pws_datapath #(
    .TUBES(TUBES), .VAL_W(VAL_W), .SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD),
    .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .reqPivot(reqPivot),
    .driftCounts(driftCounts), .bitOut(bitOut)
  );

  assign serOut = busy & bitOut;
endmodule

// File: rtl/pws_chk.sv
`timescale 1ns/1ps
module pws_chk #(
  parameter int FRAME_LEN    = 80,
  parameter int CLKS_PER_BIT = 2,
  parameter int SYNC_W       = 7,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 7'b1110010
) (
  input logic clk,
  input logic rst_n,
  input logic reqValid,
  input logic busy,
  input logic serOut
);
  localparam int TOTAL = FRAME_LEN * CLKS_PER_BIT;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] frameCyc;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) frameCyc <= '0;
    else                 frameCyc <= frameCyc + 1'b1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !serOut);

  // R2
  req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !busy) |=> busy);

  // R3
  sync_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (serOut == SYNC_WORD[SYNC_W-1]));

  // R8
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (int'(frameCyc) % CLKS_PER_BIT != 0)) |-> $stable(serOut));

  // R8
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (int'(frameCyc) == TOTAL));

  // R9
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(frameCyc) < TOTAL - 1) |=> busy);
endmodule

bind pivot_window_serializer pws_chk #(
  .FRAME_LEN(FRAME_LEN), .CLKS_PER_BIT(CLKS_PER_BIT),
  .SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .busy(busy), .serOut(serOut)
);

// File: tb/pivot_window_serializer_tb_top.sv
`timescale 1ns/1ps
module pivot_window_serializer_tb_top;
  localparam int TUBES = 8;
  localparam int VW    = 7;
  localparam int CPB   = 2;
  localparam int FLEN  = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqPivot = '0;
  logic [3*TUBES*VW-1:0] driftCounts = '0;
  logic busy, serOut;

  always #4 clk = ~clk;

  pivot_window_serializer #(.TUBES(TUBES), .VAL_W(VW), .CLKS_PER_BIT(CPB)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqPivot(reqPivot),
    .driftCounts(driftCounts), .busy(busy), .serOut(serOut)
  );

  int cnt [3][TUBES];
  int nChecks = 0;
  int nFail = 0;
  string scen = "R1";

  bit mBusy = 0;
  int mDiv = 0;
  bit q[$];

  task automatic check(input bit cond, input string req, input int act, input int exp);
    nChecks++;
    if (!cond) begin
      nFail++;
      $display("FAIL %s/%s actual=%0d expected=%0d t=%0t", scen, req, act, exp, $time);
    end
  endtask

  task automatic setCounts(input int seed);
    for (int l = 0; l < 3; l++)
      for (int t = 0; t < TUBES; t++) begin
        cnt[l][t] = (l*37 + t*11 + seed*29 + (seed ^ t)) % 128;
        driftCounts[(l*TUBES + t)*VW +: VW] = VW'(cnt[l][t]);
      end
  endtask

  task automatic buildFrame(input int piv);
    int ones;
    int vals[9];
    bit syncBits[7] = '{1,1,1,0,0,1,0};
    q.delete();
    foreach (syncBits[i]) q.push_back(syncBits[i]);
    for (int s = 0; s < 9; s++) begin
      int c;
      c = piv + (s % 3) - 1;
      vals[s] = (c < 0 || c >= TUBES) ? 0 : cnt[s/3][c];
      for (int b = VW-1; b >= 0; b--) q.push_back(vals[s][b]);
    end
    for (int s = 0; s < 9; s++) q.push_back(^vals[s][VW-1:0]);
    ones = 0;
    foreach (q[i]) ones += q[i];
    q.push_back(ones % 2);
  endtask

  function automatic string region();
    int pos;
    pos = FLEN - q.size();
    if (pos < 7)  return "R3";
    if (pos < 70) return "R4";
    if (pos < 79) return "R6";
    return "R7";
  endfunction

  // compare outputs with the model, then advance the model across the next edge
  task automatic step();
    bit expOut;
    expOut = mBusy ? q[0] : 1'b0;
    check(busy == mBusy, "R8", int'(busy), int'(mBusy));
    check(serOut == expOut, mBusy ? region() : "R1", int'(serOut), int'(expOut));
    if (mBusy) begin
      mDiv++;
      if (mDiv == CPB) begin
        mDiv = 0;
        void'(q.pop_front());
        if (q.size() == 0) mBusy = 0;
      end
    end else if (rst_n && reqValid) begin
      buildFrame(int'(reqPivot));
      mBusy = 1;
      mDiv = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runFrame(input int piv, input int seed, input string tag);
    scen = tag;
    setCounts(seed);
    reqPivot = 3'(piv);
    reqValid = 1'b1;
    step();
    reqValid = 1'b0;
    check(busy == 1'b1, "R2", int'(busy), 1);
    for (int i = 0; i < FLEN*CPB + 3; i++) step();
  endtask

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    setCounts(0);
    @(negedge clk);
    @(negedge clk);
    scen = "R1";
    check(busy == 1'b0, "R1", int'(busy), 0);
    check(serOut == 1'b0, "R1", int'(serOut), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();

    // full window, several count patterns
    runFrame(3, 1, "R4");
    runFrame(5, 2, "R6");
    runFrame(4, 7, "R7");

    // window edges
    runFrame(0, 3, "R5");
    runFrame(7, 4, "R5");

    // requests during a frame are ignored, counts changed during a frame
    scen = "R9";
    setCounts(5);
    reqPivot = 3'd2;
    reqValid = 1'b1;
    step();
    reqValid = 1'b0;
    for (int i = 0; i < 20; i++) step();
    reqValid = 1'b1;
    reqPivot = 3'd6;
    step();
    step();
    reqValid = 1'b0;
    scen = "R10";
    setCounts(9);
    reqPivot = 3'd0;
    for (int i = 0; i < FLEN*CPB + 5; i++) step();
    check(busy == 1'b0, "R9", int'(busy), 0);

    // back-to-back with request held high
    scen = "R11";
    setCounts(6);
    reqPivot = 3'd1;
    reqValid = 1'b1;
    for (int i = 0; i < 2*(FLEN*CPB + 1) + 2; i++) step();
    reqValid = 1'b0;
    for (int i = 0; i < FLEN*CPB + 4; i++) step();
    check(busy == 1'b0, "R11", int'(busy), 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule